// File: doc/BRIEF.md
# Event-Wait and Wake-Vector Controller

This block sequences clock gating and wake-up for a small microcontroller core. The core's decoder hands it a wait or sleep instruction together with a 3-bit event selector. For a wait, the block stops the core clock enable until the chosen event line has the level the instruction asks for. If that line already has the level, the clock keeps running and the core moves on in the next cycle. The eight event lines pass through a two-flop synchronizer before any comparison.

A sleep instruction also stops the clock. If the power domain is set to accept it, the block raises a low-power request. Four wake vectors, each with an enable, an event-line select and a 16-bit resume address, compete under fixed priority, and the lowest index wins. When one of them fires, the block first drops the low-power request. One cycle later it turns the clock enable back on and presents the winning resume address with a one-cycle valid pulse.

The clock gate cell itself and the power sequencing sit outside this block. It only drives the enable and the request.

Top module: `evw_ctrl`

## Requirements
- R1: While reset is held and right after it, `core_clk_en` is 1, `lp_req` is 0, `resume_valid` is 0 and `resume_addr` is 0.
- R2: An accepted `op_kind` = 0 (wait-for-low) whose selected line (index `op_sel`) is not 0 in the synchronized inputs clears `core_clk_en` at the next rising edge. The enable returns to 1 at the third rising edge after that line goes to 0, and is still 0 at the second edge.
- R3: An accepted `op_kind` = 1 (wait-for-high) behaves as R2 but waits for the selected line to be 1.
- R4: A wait whose selected synchronized line already has the required level leaves `core_clk_en` at 1 on every cycle.
- R5: While a wait is in progress, a change on any line other than the selected one has no effect on `core_clk_en`.
- R6: An accepted `op_kind` = 2 (sleep) clears `core_clk_en` at the next edge. At that same edge `lp_req` takes the value of `lp_allow`.
- R7: Vector i fires when bit i of `vec_en` is 1 and the synchronized event line named by `vec_src[3i+2:3i]` is 1. While sleeping, `lp_req` falls at the third edge after that line rises. One edge later, `core_clk_en` returns to 1 and `resume_valid` is 1 for exactly one cycle, with `resume_addr` = `vec_addr[16i+15:16i]`. `resume_addr` holds its value afterwards.
- R8: When several vectors fire in the same cycle, the lowest index wins.
- R9: A vector whose enable bit is 0 never wakes the core, even when its line is high.
- R10: An `op_valid` pulse is ignored while the clock enable is low, and `op_kind` = 3 is ignored at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 8 | Asynchronous event lines |
| op_valid | input | 1 | Decoded wait/sleep instruction strobe |
| op_kind | input | 2 | 0 wait-low, 1 wait-high, 2 sleep, 3 no-op |
| op_sel | input | 3 | Event line index for a wait |
| lp_allow | input | 1 | Power domain accepts a low-power request |
| vec_en | input | 4 | Enable bit per wake vector |
| vec_src | input | 12 | Event line select per vector, 3 bits each |
| vec_addr | input | 64 | Resume address per vector, 16 bits each |
| core_clk_en | output | 1 | Core clock enable |
| lp_req | output | 1 | Low-power request to the power domain |
| resume_valid | output | 1 | One-cycle pulse when a sleep resumes |
| resume_addr | output | 16 | Resume program counter from the winning vector |

## Verification
Waits are issued with the selected line at the wrong level and then released. This pins down the two-edge synchronizer delay against the single state register. Waits issued with the line already at the required level must not cause any stall.

Toggles on unselected lines and on a disabled vector's line show that the selector and the enable mask actually filter. Sleeps woken by two vectors at once, and then by one vector alone, separate priority from plain detection. Sleeps with `lp_allow` set and clear show that the request follows the permission rather than the instruction.

// File: rtl/evw_pkg.sv
package evw_pkg;
  typedef enum logic [1:0] {
    OP_WAIT_LO = 2'd0,
    OP_WAIT_HI = 2'd1,
    OP_SLEEP   = 2'd2,
    OP_NONE    = 2'd3
  } evw_op_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } evw_state_e;

  // Required line level for a wait opcode
  function automatic logic wait_level(input evw_op_e k);
    return (k == OP_WAIT_HI);
  endfunction

  function automatic logic is_wait(input evw_op_e k);
    return (k == OP_WAIT_LO) || (k == OP_WAIT_HI);
  endfunction
endpackage

// File: rtl/evw_sync.sv
module evw_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async[b]};
      end
      assign q_sync[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/evw_vec_arb.sv
module evw_vec_arb #(
  parameter int NVEC = 4,
  parameter int NEVT = 8,
  parameter int AW   = 16,
  localparam int SELW = $clog2(NEVT)
) (
  input  logic [NEVT-1:0]      evt_s,
  input  logic [NVEC-1:0]      vec_en,
  input  logic [NVEC*SELW-1:0] vec_src,
  input  logic [NVEC*AW-1:0]   vec_addr,
  output logic [NVEC-1:0]      hit,
  output logic [NVEC-1:0]      win_onehot,
  output logic                 any_hit,
  output logic [AW-1:0]        win_addr
);
  // Lowest set index wins: scan high to low so the last write is the lowest
  function automatic logic [NVEC-1:0] pick_lowest(input logic [NVEC-1:0] req);
    logic [NVEC-1:0] r;
    r = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (req[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  genvar v;
  generate
    for (v = 0; v < NVEC; v++) begin : g_vec
      assign hit[v] = vec_en[v] & evt_s[vec_src[v*SELW +: SELW]];
    end
  endgenerate

  assign win_onehot = pick_lowest(hit);
  assign any_hit    = |hit;

  always_comb begin
    win_addr = '0;
    for (int i = 0; i < NVEC; i++) begin
      if (win_onehot[i]) win_addr = win_addr | vec_addr[i*AW +: AW];
    end
  end
endmodule

// File: rtl/evw_seq.sv
module evw_seq
  import evw_pkg::*;
#(
  parameter int NEVT = 8,
  parameter int AW   = 16,
  localparam int SELW = $clog2(NEVT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [1:0]      op_kind,
  input  logic [SELW-1:0] op_sel,
  input  logic            lp_allow,
  input  logic [NEVT-1:0] evt_s,
  input  logic            any_hit,
  input  logic [AW-1:0]   win_addr,
  output logic            core_clk_en,
  output logic            lp_req,
  output logic            resume_valid,
  output logic [AW-1:0]   resume_addr,
  output evw_state_e      state,
  output logic            op_accept,
  output logic            op_met,
  output logic            hold_met
);
  evw_op_e         kind;
  logic [SELW-1:0] sel_r;
  logic            lvl_r;
  logic [AW-1:0]   wake_addr;

  assign kind      = evw_op_e'(op_kind);
  assign op_accept = op_valid && (state == ST_RUN) && (kind != OP_NONE);
  assign op_met    = (evt_s[op_sel] == wait_level(kind));
  assign hold_met  = (evt_s[sel_r] == lvl_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_RUN;
      core_clk_en  <= 1'b1;
      lp_req       <= 1'b0;
      resume_valid <= 1'b0;
      resume_addr  <= '0;
      wake_addr    <= '0;
      sel_r        <= '0;
      lvl_r        <= 1'b0;
    end else begin
      resume_valid <= 1'b0;
      unique case (state)
        ST_RUN: begin
          if (op_accept) begin
            if (is_wait(kind)) begin
              sel_r <= op_sel;
              lvl_r <= wait_level(kind);
              if (!op_met) begin
                state       <= ST_WAIT;
                core_clk_en <= 1'b0;
              end
            end else begin
              state       <= ST_SLEEP;
              core_clk_en <= 1'b0;
              lp_req      <= lp_allow;
            end
          end
        end
        ST_WAIT: begin
          if (hold_met) begin
            state       <= ST_RUN;
            core_clk_en <= 1'b1;
          end
        end
        ST_SLEEP: begin
          if (any_hit) begin
            state     <= ST_WAKE;
            lp_req    <= 1'b0;
            wake_addr <= win_addr;
          end
        end
        ST_WAKE: begin
          state        <= ST_RUN;
          core_clk_en  <= 1'b1;
          resume_valid <= 1'b1;
          resume_addr  <= wake_addr;
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/evw_ctrl.sv
module evw_ctrl
  import evw_pkg::*;
#(
  parameter int NEVT = 8,
  parameter int NVEC = 4,
  parameter int AW   = 16,
  localparam int SELW = $clog2(NEVT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NEVT-1:0]      evt_in,
  input  logic                 op_valid,
  input  logic [1:0]           op_kind,
  input  logic [SELW-1:0]      op_sel,
  input  logic                 lp_allow,
  input  logic [NVEC-1:0]      vec_en,
  input  logic [NVEC*SELW-1:0] vec_src,
  input  logic [NVEC*AW-1:0]   vec_addr,
  output logic                 core_clk_en,
  output logic                 lp_req,
  output logic                 resume_valid,
  output logic [AW-1:0]        resume_addr
);
  // Named internal events, visible to the bound checker
  logic [NEVT-1:0] evt_s;
  logic [NVEC-1:0] hit;
  logic [NVEC-1:0] win_onehot;
  logic            any_hit;
  logic [AW-1:0]   win_addr;
  evw_state_e      state;
  logic            op_accept;
  logic            op_met;
  logic            hold_met;
  logic            in_wait;
  logic            in_run;
  logic            op_is_wait;

  assign in_wait    = (state == ST_WAIT);
  assign in_run     = (state == ST_RUN);
  assign op_is_wait = is_wait(evw_op_e'(op_kind));

  evw_sync #(.WIDTH(NEVT), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(evt_in), .q_sync(evt_s)
  );

  evw_vec_arb #(.NVEC(NVEC), .NEVT(NEVT), .AW(AW)) u_arb (
    .evt_s(evt_s), .vec_en(vec_en), .vec_src(vec_src), .vec_addr(vec_addr),
    .hit(hit), .win_onehot(win_onehot), .any_hit(any_hit), .win_addr(win_addr)
  );

  evw_seq #(.NEVT(NEVT), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_sel(op_sel), .lp_allow(lp_allow), .evt_s(evt_s), .any_hit(any_hit),
    .win_addr(win_addr), .core_clk_en(core_clk_en), .lp_req(lp_req),
    .resume_valid(resume_valid), .resume_addr(resume_addr), .state(state),
    .op_accept(op_accept), .op_met(op_met), .hold_met(hold_met)
  );
endmodule

// File: rtl/evw_checker.sv
module evw_checker #(
  parameter int NVEC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            core_clk_en,
  input logic            lp_req,
  input logic            resume_valid,
  input logic            op_valid,
  input logic            op_is_wait,
  input logic            op_met,
  input logic            hold_met,
  input logic            in_run,
  input logic            in_wait,
  input logic [NVEC-1:0] vec_en,
  input logic [NVEC-1:0] win_onehot
);
  a_r6_lp_only_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req |-> !core_clk_en);

  a_r7_resume_at_restart: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |-> (core_clk_en && !$past(core_clk_en)));

  a_r7_lp_gone_before_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> !$past(lp_req));

  a_r4_met_keeps_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && op_valid && op_is_wait && op_met) |=> core_clk_en);

  a_r2_unmet_stays_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !hold_met) |=> !core_clk_en);

  a_r8_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_onehot));

  a_r9_disabled_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (win_onehot & ~vec_en) == '0);

  a_r10_stopped_ignores_op: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && !in_run && !lp_req) |=> !lp_req);
endmodule

bind evw_ctrl evw_checker #(.NVEC(NVEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_clk_en(core_clk_en), .lp_req(lp_req),
  .resume_valid(resume_valid), .op_valid(op_valid), .op_is_wait(op_is_wait),
  .op_met(op_met), .hold_met(hold_met), .in_run(in_run), .in_wait(in_wait),
  .vec_en(vec_en), .win_onehot(win_onehot)
);

// File: tb/evw_ctrl_test.sv
module evw_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_in = 8'h00;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'd3;
  logic [2:0]  op_sel = 3'd0;
  logic        lp_allow = 1'b0;
  logic [3:0]  vec_en;
  logic [11:0] vec_src;
  logic [63:0] vec_addr;
  logic        core_clk_en, lp_req, resume_valid;
  logic [15:0] resume_addr;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    int          at;
    bit          ce;
    bit          lp;
    bit          rv;
    logic [15:0] ra;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  evw_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .op_valid(op_valid),
    .op_kind(op_kind), .op_sel(op_sel), .lp_allow(lp_allow),
    .vec_en(vec_en), .vec_src(vec_src), .vec_addr(vec_addr),
    .core_clk_en(core_clk_en), .lp_req(lp_req),
    .resume_valid(resume_valid), .resume_addr(resume_addr)
  );

  task automatic compare(exp_t e);
    n_chk++;
    if (core_clk_en !== e.ce || lp_req !== e.lp || resume_valid !== e.rv ||
        resume_addr !== e.ra) begin
      n_fail++;
      $display("FAIL %s cyc=%0d got ce=%b lp=%b rv=%b ra=%h exp ce=%b lp=%b rv=%b ra=%h",
               e.req, cyc, core_clk_en, lp_req, resume_valid, resume_addr,
               e.ce, e.lp, e.rv, e.ra);
    end
  endtask

  // Monitor: pops scoreboard items due in this cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      if (e.at == cyc) compare(e);
      else begin
        n_chk++; n_fail++;
        $display("FAIL %s missed slot at=%0d now=%0d", e.req, e.at, cyc);
      end
    end
  end

  task automatic expect_at(int at, bit ce, bit lp, bit rv, logic [15:0] ra, string req);
    exp_t e;
    e.at = at; e.ce = ce; e.lp = lp; e.rv = rv; e.ra = ra; e.req = req;
    sb.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive one instruction strobe; captured at the next rising edge
  task automatic issue(logic [1:0] k, logic [2:0] s);
    op_valid = 1'b1; op_kind = k; op_sel = s;
    @(negedge clk);
    op_valid = 1'b0; op_kind = 2'd3;
  endtask

  initial begin : watchdog
    #(20 * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    int c;
    logic [15:0] ra;
    ra = 16'h0000;
    // v0: line1 @1000, v1: line3 @2222, v2: line4 @3333 disabled, v3: line7 @4444
    vec_en   = 4'b1011;
    vec_src  = {3'd7, 3'd4, 3'd3, 3'd1};
    vec_addr = {16'h4444, 16'h3333, 16'h2222, 16'h1000};
    evt_in   = 8'h04;
    step(3);
    // R1: values during reset
    compare('{at: cyc, ce: 1, lp: 0, rv: 0, ra: 16'h0, req: "R1 in reset"});
    rst_n = 1'b1;
    c = cyc; expect_at(c + 1, 1, 0, 0, ra, "R1 after reset");
    step(3);

    // R2 wait-low on line 2 (currently high)
    c = cyc; issue(2'd0, 3'd2); expect_at(c + 1, 0, 0, 0, ra, "R2 stop");
    step(2);
    // R5: unselected line toggles
    c = cyc; evt_in[5] = 1'b1;
    expect_at(c + 3, 0, 0, 0, ra, "R5 other line");
    expect_at(c + 4, 0, 0, 0, ra, "R5 other line");
    step(5);
    // R10: sleep strobe while stopped
    c = cyc; issue(2'd2, 3'd0);
    expect_at(c + 1, 0, 0, 0, ra, "R10 ignored op");
    expect_at(c + 2, 0, 0, 0, ra, "R10 ignored op");
    step(2);
    c = cyc; evt_in[2] = 1'b0;
    expect_at(c + 2, 0, 0, 0, ra, "R2 not yet");
    expect_at(c + 3, 1, 0, 0, ra, "R2 release");
    expect_at(c + 4, 1, 0, 0, ra, "R10 no sleep after");
    step(6);

    // R3 wait-high on line 6 (low)
    c = cyc; issue(2'd1, 3'd6); expect_at(c + 1, 0, 0, 0, ra, "R3 stop");
    step(3);
    c = cyc; evt_in[6] = 1'b1;
    expect_at(c + 2, 0, 0, 0, ra, "R3 not yet");
    expect_at(c + 3, 1, 0, 0, ra, "R3 release");
    step(5);

    // R4: already satisfied waits
    c = cyc; issue(2'd1, 3'd6);
    expect_at(c + 1, 1, 0, 0, ra, "R4 high met");
    expect_at(c + 2, 1, 0, 0, ra, "R4 high met");
    step(2);
    c = cyc; issue(2'd0, 3'd2);
    expect_at(c + 1, 1, 0, 0, ra, "R4 low met");
    expect_at(c + 2, 1, 0, 0, ra, "R4 low met");
    step(2);
    // R10: op_kind 3 has no effect
    c = cyc; issue(2'd3, 3'd2);
    expect_at(c + 1, 1, 0, 0, ra, "R10 noop kind");
    step(2);

    // R6 sleep with permission
    lp_allow = 1'b1;
    c = cyc; issue(2'd2, 3'd0); expect_at(c + 1, 0, 1, 0, ra, "R6 lp on");
    step(3);
    // R9 disabled vector's line
    c = cyc; evt_in[4] = 1'b1;
    expect_at(c + 3, 0, 1, 0, ra, "R9 disabled");
    expect_at(c + 5, 0, 1, 0, ra, "R9 disabled");
    step(6);
    // R8: vectors 1 and 3 together
    c = cyc; evt_in[7] = 1'b1; evt_in[3] = 1'b1;
    expect_at(c + 2, 0, 1, 0, ra, "R7 lp held");
    expect_at(c + 3, 0, 0, 0, ra, "R7 lp drop");
    ra = 16'h2222;
    expect_at(c + 4, 1, 0, 1, ra, "R8 priority v1");
    expect_at(c + 5, 1, 0, 0, ra, "R7 pulse ends");
    step(7);

    // R6 sleep without permission, v0 and v3 fire
    evt_in[7] = 1'b0; evt_in[3] = 1'b0; evt_in[4] = 1'b0;
    step(4);
    lp_allow = 1'b0;
    c = cyc; issue(2'd2, 3'd0); expect_at(c + 1, 0, 0, 0, ra, "R6 lp off");
    step(3);
    c = cyc; evt_in[1] = 1'b1; evt_in[7] = 1'b1;
    ra = 16'h1000;
    expect_at(c + 4, 1, 0, 1, ra, "R8 priority v0");
    step(7);

    // R7 single low-priority vector
    evt_in[1] = 1'b0; evt_in[7] = 1'b0;
    step(4);
    c = cyc; issue(2'd2, 3'd0); expect_at(c + 1, 0, 0, 0, ra, "R7 sleep");
    step(3);
    c = cyc; evt_in[7] = 1'b1;
    expect_at(c + 3, 0, 0, 0, ra, "R7 wake pending");
    ra = 16'h4444;
    expect_at(c + 4, 1, 0, 1, ra, "R7 v3 address");
    expect_at(c + 6, 1, 0, 0, ra, "R7 address held");
    step(8);

    while (sb.size() > 0) step(1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule